// File: doc/BRIEF.md
# PWM Timer with Shadowed Duty Compare

This block is an 8-bit up-counter that makes a pulse-width-modulated waveform from two compare values. The period compare sets where the counter wraps back to zero. The duty compare sets where the output falls back to its inactive level within each period. The counter only advances on cycles where a count-clock enable pulse is present. A prescaler outside the block supplies that pulse.

A duty value written while the timer runs is not applied at once. It is parked in a shadow latch. It is moved into the active duty register only when the counter next hits the duty value still in force, and only if enough count pulses have passed since the write. This way, changing the duty never leaves a period with a torn edge. Each period wrap raises a one-cycle interrupt pulse. A polarity input selects whether the active level is high or low.

Top module: `pwm_shadow_timer`

## Requirements
- R1: While reset is asserted, `cnt_o` is 00H, `pmatch_irq` is 0, `pwm_o` is at the inactive level, and the period and duty compare registers are set to FFH and 00H.
- R2: While `run` is 1, the counter changes only on cycles with `tick` = 1. After `run` rises, the counter holds 00H through the first tick and counts up from the second tick onward.
- R3: On a tick with the counter equal to the period compare, the counter returns to 00H on the next clock, the output goes active, and `pmatch_irq` is 1 for exactly that one clock.
- R4: On a tick with the counter equal to the active duty compare (and not equal to the period compare), the output goes inactive. The counter keeps counting and no interrupt is raised.
- R5: From `run` rising until the first period match, `pwm_o` stays at the inactive level.
- R6: A duty write while running goes to the shadow latch. The active duty compare, and so the current waveform, is unchanged by it.
- R7: A pending shadow value is copied to the active duty compare on a duty match against the old value, provided at least three ticks were sampled after the write cycle and before the matching tick. The output therefore uses the new value from the following period.
- R8: If the duty match comes before three such ticks have passed, or falls in the same cycle as a new duty write, the copy is skipped. The value stays pending for the next duty match, and a same-cycle write replaces it and restarts the count.
- R9: One clock after `run` is sampled 0, `pmatch_irq` is 0, `pwm_o` is inactive, the counter is 00H, and any pending shadow value is dropped.
- R10: With `pol` = 0 the active level is high. With `pol` = 1 it is low, so `pwm_o` is the internal active flag XOR `pol`.
- R11: While `run` is 0, a duty write goes straight into the active duty compare. A period write always takes effect at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count-clock enable pulse |
| run | input | 1 | Timer enable |
| pol | input | 1 | Output polarity (0: active high) |
| per_we | input | 1 | Period compare write strobe |
| per_wdata | input | W | Period compare write value |
| dut_we | input | 1 | Duty compare write strobe |
| dut_wdata | input | W | Duty compare write value |
| pwm_o | output | 1 | PWM output level |
| pmatch_irq | output | 1 | One-cycle period-match pulse |
| cnt_o | output | W | Current counter value |

## Verification
Two events can land in the same clock: a duty write and the duty match that would otherwise copy the shadow value. The bench provokes this by timing a write to reach the design on the exact tick where the counter equals the old duty value. It then checks that the next period still falls at the old point, and that the replacement value takes over one period later. A period match and a duty match can also coincide when both compares are equal. Constrained random runs with small periods and duty values at or above the period produce that case. A cycle-accurate bench model judges the counter, interrupt and output on every cycle.

// File: rtl/pwm_shadow_timer.sv
module pwm_shadow_timer #(
  parameter int W = 8,
  parameter int GUARD = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         pol,
  input  logic         per_we,
  input  logic [W-1:0] per_wdata,
  input  logic         dut_we,
  input  logic [W-1:0] dut_wdata,
  output logic         pwm_o,
  output logic         pmatch_irq,
  output logic [W-1:0] cnt_o
);
  localparam int AW = $clog2(GUARD + 1);
  localparam logic [AW-1:0] RIPE_AGE = AW'(GUARD);

  logic [W-1:0]  cnt, per, dut_act, dut_sh;
  logic          act, irq, prim, pend;
  logic [AW-1:0] age;

  wire step    = run & tick & prim;
  wire per_hit = step & (cnt == per);
  wire dut_hit = step & (cnt == dut_act) & (cnt != per);
  wire ripe    = pend & (age == RIPE_AGE);
  wire xfer    = dut_hit & ripe & ~dut_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      per     <= '1;
      dut_act <= '0;
      dut_sh  <= '0;
      act     <= 1'b0;
      irq     <= 1'b0;
      prim    <= 1'b0;
      pend    <= 1'b0;
      age     <= '0;
    end else begin
      if (per_we) per <= per_wdata;
      if (!run) begin
        cnt  <= '0;
        act  <= 1'b0;
        irq  <= 1'b0;
        prim <= 1'b0;
        pend <= 1'b0;
        age  <= '0;
        if (dut_we) dut_act <= dut_wdata;
      end else begin
        irq <= per_hit;
        if (tick && !prim) prim <= 1'b1;
        if (per_hit) begin
          cnt <= '0;
          act <= 1'b1;
        end else if (step) begin
          cnt <= cnt + 1'b1;
          if (dut_hit) act <= 1'b0;
        end
        if (dut_we) begin
          dut_sh <= dut_wdata;
          pend   <= 1'b1;
          age    <= '0;
        end else begin
          if (xfer) begin
            dut_act <= dut_sh;
            pend    <= 1'b0;
          end
          if (tick && pend && !ripe) age <= age + 1'b1;
        end
      end
    end
  end

  assign pwm_o      = act ^ pol;
  assign pmatch_irq = irq;
  assign cnt_o      = cnt;

  p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pmatch_irq |-> (cnt_o == '0) && act);

  p_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!pmatch_irq && !act && cnt_o == '0 && !pend));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt_o));

  p_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && dut_we) |=> $stable(dut_act));

  p_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && pend && age < RIPE_AGE) |=> $stable(dut_act));
endmodule

// File: tb/sim_pwm_shadow_timer.sv
`timescale 1ns/1ps
module sim_pwm_shadow_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, run = 1'b0, pol = 1'b0;
  logic per_we = 1'b0, dut_we = 1'b0;
  logic [7:0] per_wd = '0, dut_wd = '0;
  logic pwm, irq;
  logic [7:0] cnt;
  int n_chk = 0, n_bad = 0;
  bit cmp_on = 1'b0, done = 1'b0;

  logic [7:0] m_cnt, m_per, m_dact, m_dsh;
  logic m_act, m_irq, m_prim, m_pend;
  int m_age;

  always #2.5 clk = ~clk;

  pwm_shadow_timer u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .pol(pol),
    .per_we(per_we), .per_wdata(per_wd), .dut_we(dut_we), .dut_wdata(dut_wd),
    .pwm_o(pwm), .pmatch_irq(irq), .cnt_o(cnt)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin : mdl
    logic hp, hd, rp;
    if (!rst_n) begin
      m_cnt = 0; m_act = 0; m_irq = 0; m_prim = 0; m_pend = 0; m_age = 0;
      m_per = 8'hFF; m_dact = 0; m_dsh = 0;
    end else if (!run) begin
      m_cnt = 0; m_act = 0; m_irq = 0; m_prim = 0; m_pend = 0; m_age = 0;
      if (dut_we) m_dact = dut_wd;
      if (per_we) m_per = per_wd;
    end else begin
      hp = tick && m_prim && (m_cnt == m_per);
      hd = tick && m_prim && (m_cnt == m_dact) && (m_cnt != m_per);
      rp = m_pend && (m_age >= 3);
      m_irq = hp;
      if (hp) begin m_cnt = 0; m_act = 1; end
      else if (tick && m_prim) begin if (hd) m_act = 0; m_cnt++; end
      if (tick && !m_prim) m_prim = 1;
      if (dut_we) begin m_dsh = dut_wd; m_pend = 1; m_age = 0; end
      else begin
        if (hd && rp) begin m_dact = m_dsh; m_pend = 0; end
        if (tick && m_pend && m_age < 3) m_age++;
      end
      if (per_we) m_per = per_wd;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 counter vs model", cnt, m_cnt);
      chk("R3 irq vs model", irq, m_irq);
      chk("R4 pwm vs model", pwm, m_act ^ pol);
    end
  end

  task automatic wr_stopped(input logic [7:0] p, input logic [7:0] d);
    @(negedge clk); #1;
    per_we = 1; per_wd = p; dut_we = 1; dut_wd = d;
    @(negedge clk); #1;
    per_we = 0; dut_we = 0;
  endtask

  task automatic wait_irq(input bit low_chk, output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
      if (low_chk && !irq) chk("R5 inactive before first match", pwm, pol);
    end while (!irq);
  endtask

  task automatic period(input int wr_at, input logic [7:0] wv, output int hi, output int len);
    hi = 0; len = 0;
    do begin
      hi += int'(pwm ^ pol);
      len++;
      if (len - 1 == wr_at) begin #1; dut_we = 1; dut_wd = wv; end
      @(negedge clk);
      if (dut_we) begin #1; dut_we = 0; end
    end while (!irq);
  endtask

  initial begin
    int n, hi, len;
    void'($urandom(32'd20240));
    repeat (3) @(negedge clk);
    chk("R1 reset counter", cnt, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset pwm", pwm, 0);
    #1 rst_n = 1;
    cmp_on = 1;

    wr_stopped(8'hA5, 8'h02);
    @(negedge clk); #1; run = 1; tick = 1;
    @(negedge clk); chk("R2 first tick masked", cnt, 0);
    @(negedge clk); chk("R2 counting after mask", cnt, 1);
    wait_irq(1'b1, n);
    chk("R5 first match cycle count", n + 2, 167);
    chk("R3 wrap to zero", cnt, 0);
    chk("R3 active at wrap", pwm, 1);

    period(16, 8'h03, hi, len);
    chk("R3 period length", len, 166);
    chk("R6 shadow write leaves duty", hi, 3);
    period(-1, 8'h00, hi, len);
    chk("R7 old duty during transfer", hi, 3);
    period(0, 8'h05, hi, len);
    chk("R7 new duty next period", hi, 4);
    period(-1, 8'h00, hi, len);
    chk("R8 late write deferred", hi, 4);
    period(-1, 8'h00, hi, len);
    chk("R8 deferred value applied", hi, 6);
    period(10, 8'h07, hi, len);
    chk("R4 duty 05 active time", hi, 6);
    period(5, 8'h09, hi, len);
    chk("R8 write at match blocks copy", hi, 6);
    period(-1, 8'h00, hi, len);
    chk("R8 replaced value copied", hi, 6);
    period(-1, 8'h00, hi, len);
    chk("R8 replaced value used", hi, 10);

    #1 run = 0;
    @(negedge clk);
    chk("R9 pwm off", pwm, 0);
    chk("R9 irq off", irq, 0);
    chk("R9 counter off", cnt, 0);
    #1 pol = 1;
    @(negedge clk);
    chk("R10 inverted idle level", pwm, 1);

    wr_stopped(8'h40, 8'h20);
    @(negedge clk); #1; run = 1;
    wait_irq(1'b1, n);
    chk("R10 active low at wrap", pwm, 0);
    period(-1, 8'h00, hi, len);
    chk("R11 direct duty while stopped", hi, 33);
    chk("R11 direct period while stopped", len, 65);
    #1 run = 0;

    for (int seg = 0; seg < 40; seg++) begin
      @(negedge clk); #1;
      run = 0; pol = 1'($urandom_range(0, 1));
      per_we = 1; per_wd = 8'($urandom_range(0, 40));
      dut_we = 1; dut_wd = 8'($urandom_range(0, 45));
      @(negedge clk); #1;
      per_we = 0; dut_we = 0; run = 1;
      for (int c = 0; c < 800; c++) begin
        @(negedge clk); #1;
        tick = ($urandom_range(0, 2) != 0);
        dut_we = ($urandom_range(0, 19) == 0);
        dut_wd = 8'($urandom_range(0, 45));
        if ($urandom_range(0, 399) == 0) run = ~run;
      end
    end
    @(negedge clk); #1; dut_we = 0; run = 0;
    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule